// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the configuration front door of a detector readout chip. A controller drives three lines that are synchronous to the crossing clock: a shift-control level that frames each transaction, a serial data input and a serial data output. Each transaction starts with a 13-bit header that names a target chip, a register and an operation. The block compares the target against its own strap-set chip identity, or accepts the broadcast identity. It then changes or returns one register of an internal register file.

The register file is plain storage. It holds a bank of 8-bit bias-setting registers, a bank of 2-bit operating-mode registers and two long per-pixel mask registers, with one bit per pixel. Besides a serial write, every register can be forced to all ones, forced to all zeros or returned to its power-up value with a header-only command. A read shifts the register back out on the output line. The output line stays at 0 at all other times, so many chips can share one bus.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, registers 0 to 13 (8 bits each) hold 0x80, registers 14 to 20 (2 bits each) hold 2'b01 and registers 21 and 22 (LONG_LEN bits each, 64 by default) hold all zeros.
- R2: A transaction starts on the first clock edge at which `sc_i` is high after a cycle with `sc_i` low. The 13 header bits are sampled MSB first in this order: chip ID (5 bits), register number (5 bits), opcode (3 bits). With opcode 3'b001 (write), the next N bits form the new value, MSB first, and it takes effect on the edge of the last bit. N is the register's width.
- R3: A write to an 8-bit register or a 2-bit register stores exactly that number of bits.
- R4: A write to a long register stores all LONG_LEN bits in order.
- R5: Opcode 3'b010 sets every bit to 1, 3'b100 clears every bit to 0 and 3'b101 restores the R1 value. Each takes effect on the edge of the last header bit.
- R6: A command whose chip ID is neither `chip_id_strap` nor 31 changes no register and leaves `sout_o` at 0.
- R7: Chip ID 31 is a broadcast. Write, set, clear and default apply, but a broadcast read (opcode 3'b011) leaves `sout_o` at 0.
- R8: If `sc_i` falls before the last payload bit of a write, the register keeps its old value.
- R9: Register numbers 23 to 31 are not implemented. Commands to them change nothing, and reads of them leave `sout_o` at 0.
- R10: `sout_o` is 0 whenever `sc_i` is low and whenever no read payload is being shifted.
- R11: Opcodes 3'b000, 3'b110 and 3'b111 change no register.
- R12: With opcode 3'b011 and a matching ID, the register is driven on `sout_o` MSB first, one bit per cycle. The first bit is valid in the cycle after the edge of the last header bit. Bits beyond a completed transaction are ignored until `sc_i` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id_strap | input | 5 | Strap-set chip identity |
| sc_i | input | 1 | Shift control, high for the whole transaction |
| sin_i | input | 1 | Serial data in, sampled on rising edges |
| sout_o | output | 1 | Serial data out, 0 when not reading |

## Verification
A wrong decode state shows up at the ports quickly. A stored value is wrong on the very next read of that register, and the error is visible within 13 plus width cycles. A wrong bit counter shifts the stored value by whole bit positions, or makes the port answer a foreign, broadcast-read or unimplemented command. In that case `sout_o` goes high in a cycle where it must stay at 0, right after the last header bit. An abort handled wrongly leaves a partial value behind, which the next read of that register exposes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int HDR_ID_W  = 5;
   localparam int HDR_REG_W = 5;
   localparam int HDR_OP_W  = 3;
   localparam int HDR_LEN   = HDR_ID_W + HDR_REG_W + HDR_OP_W;

   localparam logic [HDR_ID_W-1:0] BCAST_ID = 5'd31;

   localparam logic [HDR_OP_W-1:0] OP_WRITE   = 3'b001;
   localparam logic [HDR_OP_W-1:0] OP_SET     = 3'b010;
   localparam logic [HDR_OP_W-1:0] OP_READ    = 3'b011;
   localparam logic [HDR_OP_W-1:0] OP_CLEAR   = 3'b100;
   localparam logic [HDR_OP_W-1:0] OP_DEFAULT = 3'b101;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_HDR,
      FR_WDATA,
      FR_READ,
      FR_DONE
   } frame_state_e;
endpackage

// File: rtl/cfg_reg_cell.sv
module cfg_reg_cell #(
   parameter int         W   = 8,
   parameter logic [W-1:0] DEF = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hit,
   input  logic [cfg_pkg::HDR_OP_W-1:0] op,
   input  logic [W-1:0]                wdata,
   output logic [W-1:0]                val
);
   import cfg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= DEF;
      end else if (hit) begin
         case (op)
            OP_WRITE:   val <= wdata;
            OP_SET:     val <= '1;
            OP_CLEAR:   val <= '0;
            OP_DEFAULT: val <= DEF;
            default:    val <= val;
         endcase
      end
   end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter int           N_DAC        = 14,
   parameter int           N_CTRL       = 7,
   parameter int           N_LONG       = 2,
   parameter int           DAC_W        = 8,
   parameter int           CTRL_W       = 2,
   parameter int           LONG_LEN     = 64,
   parameter logic [7:0]   DAC_DEFAULT  = 8'h80,
   parameter logic [1:0]   CTRL_DEFAULT = 2'b01,
   parameter logic         LONG_DEF_BIT = 1'b0,
   localparam int          N_IMPL       = N_DAC + N_CTRL + N_LONG,
   localparam int          MAXW         = (LONG_LEN > DAC_W) ? LONG_LEN : DAC_W,
   localparam int          LW           = $clog2(MAXW + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [cfg_pkg::HDR_OP_W-1:0]  cmd_op,
   input  logic [cfg_pkg::HDR_REG_W-1:0] cmd_reg,
   input  logic [MAXW-1:0]              cmd_wdata,
   input  logic [cfg_pkg::HDR_REG_W-1:0] rd_addr,
   output logic [MAXW-1:0]              rd_data,
   output logic [LW-1:0]                rd_len
);
   import cfg_pkg::*;

   logic [MAXW-1:0] regv [N_IMPL];

   function automatic logic [LW-1:0] len_of(input logic [HDR_REG_W-1:0] a);
      if (int'(a) < N_DAC)               return LW'(DAC_W);
      else if (int'(a) < N_DAC + N_CTRL) return LW'(CTRL_W);
      else                               return LW'(LONG_LEN);
   endfunction

   for (genvar i = 0; i < N_IMPL; i++) begin : g_reg
      localparam int W = (i < N_DAC) ? DAC_W :
                         (i < N_DAC + N_CTRL) ? CTRL_W : LONG_LEN;
      localparam logic [W-1:0] DEF = (i < N_DAC) ? W'(DAC_DEFAULT) :
                                     (i < N_DAC + N_CTRL) ? W'(CTRL_DEFAULT) :
                                     {W{LONG_DEF_BIT}};
      logic          hit;
      logic [W-1:0]  val;

      assign hit = cmd_valid && (int'(cmd_reg) == i);

      cfg_reg_cell #(.W(W), .DEF(DEF)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .hit   (hit),
         .op    (cmd_op),
         .wdata (cmd_wdata[W-1:0]),
         .val   (val)
      );

      // left-align so the frame controller always shifts from the top bit
      assign regv[i] = MAXW'(val) << (MAXW - W);
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_IMPL; i++) begin
         if (int'(rd_addr) == i) rd_data = regv[i];
      end
      rd_len = len_of(rd_addr);
   end
endmodule

// File: rtl/cfg_frame_ctrl.sv
module cfg_frame_ctrl #(
   parameter  int N_IMPL = 23,
   parameter  int MAXW   = 64,
   localparam int LW     = $clog2(MAXW + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [cfg_pkg::HDR_ID_W-1:0]  strap,
   input  logic                         sc,
   input  logic                         sin,
   output logic                         sout,
   output logic [cfg_pkg::HDR_REG_W-1:0] rd_addr,
   input  logic [MAXW-1:0]              rd_data,
   input  logic [LW-1:0]                rd_len,
   output logic                         cmd_valid,
   output logic [cfg_pkg::HDR_OP_W-1:0]  cmd_op,
   output logic [cfg_pkg::HDR_REG_W-1:0] cmd_reg,
   output logic [MAXW-1:0]              cmd_wdata
);
   import cfg_pkg::*;

   frame_state_e           state;
   logic [LW-1:0]          cnt;
   logic [HDR_LEN-1:0]     hdr;
   logic [MAXW-1:0]        shreg;
   logic [HDR_REG_W-1:0]   reg_q;
   logic [LW-1:0]          len_q;

   logic [HDR_LEN-1:0]     hdr_n;
   logic [HDR_ID_W-1:0]    id_f;
   logic [HDR_REG_W-1:0]   reg_f;
   logic [HDR_OP_W-1:0]    op_f;
   logic                   hdr_end, wr_end, rd_end, addressed, impl, simple_op;

   always_comb begin
      hdr_n     = {hdr[HDR_LEN-2:0], sin};
      id_f      = hdr_n[HDR_LEN-1 -: HDR_ID_W];
      reg_f     = hdr_n[HDR_OP_W +: HDR_REG_W];
      op_f      = hdr_n[HDR_OP_W-1:0];
      rd_addr   = reg_f;
      addressed = (id_f == strap) || (id_f == BCAST_ID);
      impl      = int'(reg_f) < N_IMPL;
      simple_op = (op_f == OP_SET) || (op_f == OP_CLEAR) || (op_f == OP_DEFAULT);
      hdr_end   = (state == FR_HDR) && sc && (cnt == LW'(HDR_LEN - 1));
      wr_end    = (state == FR_WDATA) && sc && (cnt == len_q - LW'(1));
      rd_end    = (state == FR_READ) && sc && (cnt == len_q - LW'(1));
      cmd_valid = (hdr_end && addressed && impl && simple_op) || wr_end;
      cmd_op    = wr_end ? OP_WRITE : op_f;
      cmd_reg   = wr_end ? reg_q : reg_f;
      cmd_wdata = {shreg[MAXW-2:0], sin};
      sout      = (state == FR_READ) && sc && shreg[MAXW-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FR_IDLE;
         cnt   <= '0;
         hdr   <= '0;
         shreg <= '0;
         reg_q <= '0;
         len_q <= '0;
      end else if (!sc) begin
         state <= FR_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            FR_IDLE: begin
               hdr   <= HDR_LEN'(sin);
               cnt   <= LW'(1);
               state <= FR_HDR;
            end
            FR_HDR: begin
               hdr <= hdr_n;
               cnt <= cnt + LW'(1);
               if (hdr_end) begin
                  cnt   <= '0;
                  reg_q <= reg_f;
                  len_q <= rd_len;
                  state <= FR_DONE;
                  if (addressed && impl) begin
                     if (op_f == OP_WRITE) begin
                        state <= FR_WDATA;
                     end else if (op_f == OP_READ && id_f != BCAST_ID) begin
                        state <= FR_READ;
                        shreg <= rd_data;
                     end
                  end
               end
            end
            FR_WDATA: begin
               shreg <= cmd_wdata;
               cnt   <= cnt + LW'(1);
               if (wr_end) state <= FR_DONE;
            end
            FR_READ: begin
               shreg <= shreg << 1;
               cnt   <= cnt + LW'(1);
               if (rd_end) state <= FR_DONE;
            end
            default: state <= FR_DONE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
   parameter int         N_DAC        = 14,
   parameter int         N_CTRL       = 7,
   parameter int         N_LONG       = 2,
   parameter int         DAC_W        = 8,
   parameter int         CTRL_W       = 2,
   parameter int         LONG_LEN     = 64,
   parameter logic [7:0] DAC_DEFAULT  = 8'h80,
   parameter logic [1:0] CTRL_DEFAULT = 2'b01,
   parameter logic       LONG_DEF_BIT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [4:0] chip_id_strap,
   input  logic       sc_i,
   input  logic       sin_i,
   output logic       sout_o
);
   import cfg_pkg::*;

   localparam int N_IMPL = N_DAC + N_CTRL + N_LONG;
   localparam int MAXW   = (LONG_LEN > DAC_W) ? LONG_LEN : DAC_W;
   localparam int LW     = $clog2(MAXW + 1);

   if (N_IMPL > (1 << HDR_REG_W) - 1) begin : g_bad_count
      $error("register file exceeds the address space");
   end
   if (DAC_W > 8 || CTRL_W > 2 || CTRL_W > DAC_W) begin : g_bad_width
      $error("short register widths out of range");
   end
   if (LONG_LEN < DAC_W || N_LONG < 0) begin : g_bad_long
      $error("long register shorter than a bias register");
   end

   logic                 cmd_valid;
   logic [HDR_OP_W-1:0]  cmd_op;
   logic [HDR_REG_W-1:0] cmd_reg;
   logic [MAXW-1:0]      cmd_wdata;
   logic [HDR_REG_W-1:0] rd_addr;
   logic [MAXW-1:0]      rd_data;
   logic [LW-1:0]        rd_len;

   cfg_frame_ctrl #(.N_IMPL(N_IMPL), .MAXW(MAXW)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (chip_id_strap),
      .sc        (sc_i),
      .sin       (sin_i),
      .sout      (sout_o),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rd_len    (rd_len),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_reg   (cmd_reg),
      .cmd_wdata (cmd_wdata)
   );

   cfg_reg_bank #(
      .N_DAC(N_DAC), .N_CTRL(N_CTRL), .N_LONG(N_LONG),
      .DAC_W(DAC_W), .CTRL_W(CTRL_W), .LONG_LEN(LONG_LEN),
      .DAC_DEFAULT(DAC_DEFAULT), .CTRL_DEFAULT(CTRL_DEFAULT),
      .LONG_DEF_BIT(LONG_DEF_BIT)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_reg   (cmd_reg),
      .cmd_wdata (cmd_wdata),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rd_len    (rd_len)
   );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int N_DAC    = 14,
   parameter int N_CTRL   = 7,
   parameter int N_LONG   = 2,
   parameter int DAC_W    = 8,
   parameter int CTRL_W   = 2,
   parameter int LONG_LEN = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sc,
   input logic       sin,
   input logic       sout,
   input logic [4:0] strap,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic [4:0] cmd_reg
);
   import cfg_pkg::*;

   localparam int N_IMPL = N_DAC + N_CTRL + N_LONG;

   logic [15:0] bits;
   logic [12:0] hsh;
   logic [12:0] hdr_now;
   logic        quiet_foreign, quiet_bcast;

   function automatic int exp_len(input logic [4:0] a);
      if (int'(a) < N_DAC)               return DAC_W;
      else if (int'(a) < N_DAC + N_CTRL) return CTRL_W;
      else                               return LONG_LEN;
   endfunction

   assign hdr_now = {hsh[11:0], sin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits          <= '0;
         hsh           <= '0;
         quiet_foreign <= 1'b0;
         quiet_bcast   <= 1'b0;
      end else if (!sc) begin
         bits          <= '0;
         quiet_foreign <= 1'b0;
         quiet_bcast   <= 1'b0;
      end else begin
         if (bits != 16'hFFFF) bits <= bits + 16'd1;
         if (bits < 16'd13) hsh <= hdr_now;
         if (bits == 16'd12) begin
            quiet_foreign <= (hdr_now[12:8] != strap) && (hdr_now[12:8] != BCAST_ID);
            quiet_bcast   <= (hdr_now[12:8] == BCAST_ID) && (hdr_now[2:0] == OP_READ);
         end
      end
   end

   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sc |-> !sout);

   assert_foreign_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_foreign |-> !sout);

   assert_bcast_read_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_bcast |-> !sout);

   assert_abort_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> sc);

   assert_implemented_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (int'(cmd_reg) < N_IMPL));

   assert_write_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_WRITE) |-> (int'(bits) == 12 + exp_len(cmd_reg)));

   assert_header_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op != OP_WRITE) |->
         (bits == 16'd12 && (hdr_now[12:8] == strap || hdr_now[12:8] == BCAST_ID)));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
   .N_DAC(N_DAC), .N_CTRL(N_CTRL), .N_LONG(N_LONG),
   .DAC_W(DAC_W), .CTRL_W(CTRL_W), .LONG_LEN(LONG_LEN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sc        (sc_i),
   .sin       (sin_i),
   .sout      (sout_o),
   .strap     (chip_id_strap),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_reg   (cmd_reg)
);

// File: tb/cfg_serial_port_test.sv
`timescale 1ns/1ps
module cfg_serial_port_test;
   localparam logic [4:0] MY_ID  = 5'd9;
   localparam logic [4:0] OTHER  = 5'd4;
   localparam logic [4:0] BCAST  = 5'd31;
   localparam logic [2:0] WR = 3'b001, ST = 3'b010, RD = 3'b011, CL = 3'b100, DF = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sc = 1'b0;
   logic sin = 1'b0;
   logic sout;
   int   n_tests = 0;
   int   n_fail = 0;
   logic reading = 1'b0;
   logic stray_sout = 1'b0;

   always #2.5 clk = ~clk;

   cfg_serial_port uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .chip_id_strap (MY_ID),
      .sc_i          (sc),
      .sin_i         (sin),
      .sout_o        (sout)
   );

   always @(negedge clk) if (rst_n && !reading && sout) stray_sout = 1'b1;

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   function automatic int len_of(input logic [4:0] r);
      if (r < 5'd14) return 8;
      else if (r < 5'd21) return 2;
      else return 64;
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      sc  = 1'b1;
      sin = b;
   endtask

   task automatic end_frame();
      @(negedge clk);
      sc  = 1'b0;
      sin = 1'b0;
   endtask

   task automatic send_hdr(input logic [4:0] id, input logic [4:0] r, input logic [2:0] op);
      logic [12:0] h;
      h = {id, r, op};
      for (int i = 12; i >= 0; i--) send_bit(h[i]);
   endtask

   task automatic do_write(input logic [4:0] id, input logic [4:0] r, input logic [63:0] v,
                           input int n);
      send_hdr(id, r, WR);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
      end_frame();
   endtask

   task automatic do_cmd(input logic [4:0] id, input logic [4:0] r, input logic [2:0] op);
      send_hdr(id, r, op);
      end_frame();
   endtask

   task automatic do_read(input logic [4:0] id, input logic [4:0] r, input int n,
                          output logic [63:0] v);
      send_hdr(id, r, RD);
      v = '0;
      reading = 1'b1;
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         v[i] = sout;
      end
      reading = 1'b0;
      sc  = 1'b0;
      sin = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [4:0] r, input logic [63:0] exp);
      logic [63:0] v;
      do_read(MY_ID, r, len_of(r), v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      check("R10 idle sout", {63'd0, sout}, 64'd0);
      rd_check("R1 bias reg 0", 5'd0, 64'h80);
      rd_check("R1 bias reg 13", 5'd13, 64'h80);
      rd_check("R1 mode reg 14", 5'd14, 64'h1);
      rd_check("R1 long reg 21", 5'd21, 64'h0);
   endtask

   task automatic t_write_short();
      do_write(MY_ID, 5'd5, 64'hA5, 8);
      rd_check("R3 bias write", 5'd5, 64'hA5);
      do_write(MY_ID, 5'd13, 64'h3C, 8);
      rd_check("R3 bias write last", 5'd13, 64'h3C);
      do_write(MY_ID, 5'd20, 64'h2, 2);
      rd_check("R3 mode write", 5'd20, 64'h2);
   endtask

   task automatic t_write_long();
      do_write(MY_ID, 5'd22, 64'hDEADBEEF01234567, 64);
      rd_check("R4 long write 22", 5'd22, 64'hDEADBEEF01234567);
      do_write(MY_ID, 5'd21, 64'h8000000000000001, 64);
      rd_check("R4 long write 21", 5'd21, 64'h8000000000000001);
      rd_check("R12 order after long", 5'd22, 64'hDEADBEEF01234567);
   endtask

   task automatic t_ops();
      do_cmd(MY_ID, 5'd7, ST);
      rd_check("R5 set bias", 5'd7, 64'hFF);
      do_cmd(MY_ID, 5'd7, CL);
      rd_check("R5 clear bias", 5'd7, 64'h00);
      do_cmd(MY_ID, 5'd7, DF);
      rd_check("R5 default bias", 5'd7, 64'h80);
      do_cmd(MY_ID, 5'd15, ST);
      rd_check("R5 set mode", 5'd15, 64'h3);
      do_cmd(MY_ID, 5'd21, ST);
      rd_check("R5 set long", 5'd21, 64'hFFFFFFFFFFFFFFFF);
      do_cmd(MY_ID, 5'd21, DF);
      rd_check("R5 default long", 5'd21, 64'h0);
   endtask

   task automatic t_foreign();
      logic [63:0] v;
      do_write(OTHER, 5'd5, 64'h11, 8);
      rd_check("R6 foreign write ignored", 5'd5, 64'hA5);
      do_cmd(OTHER, 5'd5, CL);
      rd_check("R6 foreign clear ignored", 5'd5, 64'hA5);
      do_read(OTHER, 5'd0, 8, v);
      check("R6 foreign read silent", v, 64'h0);
   endtask

   task automatic t_bcast();
      logic [63:0] v;
      do_write(BCAST, 5'd6, 64'h5A, 8);
      rd_check("R7 broadcast write", 5'd6, 64'h5A);
      do_cmd(BCAST, 5'd16, CL);
      rd_check("R7 broadcast clear", 5'd16, 64'h0);
      do_read(BCAST, 5'd0, 8, v);
      check("R7 broadcast read silent", v, 64'h0);
   endtask

   task automatic t_abort();
      send_hdr(MY_ID, 5'd8, WR);
      for (int i = 0; i < 7; i++) send_bit(1'b0);
      end_frame();
      rd_check("R8 abort keeps value", 5'd8, 64'h80);
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      end_frame();
      do_write(MY_ID, 5'd8, 64'h42, 8);
      rd_check("R8 recovery after short header", 5'd8, 64'h42);
   endtask

   task automatic t_unimpl();
      logic [63:0] v;
      do_write(MY_ID, 5'd25, 64'hFF, 8);
      do_cmd(MY_ID, 5'd23, ST);
      do_read(MY_ID, 5'd25, 8, v);
      check("R9 unimplemented read silent", v, 64'h0);
      rd_check("R9 neighbour untouched", 5'd0, 64'h80);
      rd_check("R9 last implemented untouched", 5'd22, 64'hDEADBEEF01234567);
   endtask

   task automatic t_opcode();
      do_cmd(MY_ID, 5'd9, 3'b000);
      do_cmd(MY_ID, 5'd9, 3'b110);
      do_cmd(MY_ID, 5'd9, 3'b111);
      rd_check("R11 bad opcodes ignored", 5'd9, 64'h80);
   endtask

   task automatic t_trailing();
      send_hdr(MY_ID, 5'd10, WR);
      for (int i = 7; i >= 0; i--) send_bit(8'h11 >> i);
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      end_frame();
      rd_check("R12 trailing bits ignored", 5'd10, 64'h11);
      check("R10 no stray sout", {63'd0, stray_sout}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_short();
      t_write_long();
      t_ops();
      t_foreign();
      t_bcast();
      t_abort();
      t_unimpl();
      t_opcode();
      t_trailing();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule